// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Resolution

This unit owns the program counter of a simple single-issue processor with no delay slot. Each cycle that the execute side retires an instruction, it offers the decoded word together with the two source register values. The unit then works out where fetch goes next: the following word, a PC-relative branch target, an absolute jump target, or a register-held address. For the call form it also produces the return address and a write strobe for the link register.

The unit also turns the PC into a word index for a small instruction store, and it counts retired instructions. A next PC of zero is the end-of-program condition. Any opcode or function code outside the supported subset forces the next PC to zero. Once the PC has reached zero, the unit raises a sticky halt flag and freezes the PC and the count until reset.

Top module: `npc_unit`

## Requirements
- R1: After reset `pc_o` equals 0x00400000, `halt_o` is 0 and `retired_o` is 0.
- R2: A retired instruction that is not a jump or a branch and is a legal member of the subset sets the PC to the old PC plus 4 on the next clock edge. The legal non-control members are: opcode 0 with function code 0, 2, 4, 6, 16, 18, 24, 25, 33, 35, 36, 37, 38, 42 or 43; and opcodes 9 to 15, 35 and 43. The opcode is bits 31:26 and the function code is bits 5:0.
- R3: `imem_idx_o` equals bits 7:2 of the PC, which gives 64 word slots.
- R4: Opcode 2 sets the next PC to bits 25:0 of the instruction shifted left by 2, with every PC bit above bit 27 cleared.
- R5: Opcode 3 computes its target the same way as opcode 2. In the same step it drives `link_we_o` high and `link_val_o` to the old PC plus 4, which is the value for register 31.
- R6: Opcode 0 with function code 8 sets the next PC to `rs_val_i`.
- R7: Opcode 4 (equal) and opcode 5 (not equal) compare `rs_val_i` with `rt_val_i`. When the branch is taken, the next PC is the branch's own PC plus the sign-extended bits 15:0 shifted left by 2. When it is not taken, the next PC is PC plus 4.
- R8: Opcode 1 is taken when bit 31 of `rs_val_i` is 0. The rt field (bits 20:16) and `rt_val_i` have no effect on it.
- R9: Any other opcode, or opcode 0 with any other function code, sets the next PC to 0.
- R10: When a retired step loads a PC of 0, `halt_o` rises on that edge and stays high until reset. While it is high, the PC does not change and `link_we_o` stays low.
- R11: `retired_o` rises by one for every step taken while not halted, including the step that halts. After that it holds.
- R12: With `step_i` low, the PC and the count hold, and `link_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Current instruction retires this cycle |
| instr_i | input | 32 | Instruction word at the current PC |
| rs_val_i | input | 32 | Value of the rs source register |
| rt_val_i | input | 32 | Value of the rt source register |
| pc_o | output | 32 | Current program counter |
| imem_idx_o | output | 6 | Word index into the instruction store |
| next_pc_o | output | 32 | PC selected for the next fetch |
| link_we_o | output | 1 | Write strobe for the link register |
| link_val_o | output | 32 | Return address for the link register |
| halt_o | output | 1 | Sticky end-of-program flag |
| retired_o | output | 16 | Count of retired instructions |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 64-slot store, a 16-bit counter and a start address of 0x00400000. With these values the word index lands on PC bits 7:2. A register jump to an address with high bits set, followed by an absolute jump, shows that the upper PC bits are dropped rather than merged. A chained vector table drives forward and backward branch offsets and both signs of the non-negative test. The halting paths are reached three ways: an illegal function code, an illegal opcode and a register jump to zero. Each one is followed by a check that the PC, the count and the link strobe stay frozen.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_BGEZ    = 6'd1;
  localparam logic [5:0] OPC_J       = 6'd2;
  localparam logic [5:0] OPC_JAL     = 6'd3;
  localparam logic [5:0] OPC_BEQ     = 6'd4;
  localparam logic [5:0] OPC_BNE     = 6'd5;
  localparam logic [5:0] OPC_ADDIU   = 6'd9;
  localparam logic [5:0] OPC_SLTI    = 6'd10;
  localparam logic [5:0] OPC_SLTIU   = 6'd11;
  localparam logic [5:0] OPC_ANDI    = 6'd12;
  localparam logic [5:0] OPC_ORI     = 6'd13;
  localparam logic [5:0] OPC_XORI    = 6'd14;
  localparam logic [5:0] OPC_LUI     = 6'd15;
  localparam logic [5:0] OPC_LW      = 6'd35;
  localparam logic [5:0] OPC_SW      = 6'd43;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SLLV = 6'd4;
  localparam logic [5:0] FN_SRLV = 6'd6;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_MFHI = 6'd16;
  localparam logic [5:0] FN_MFLO = 6'd18;
  localparam logic [5:0] FN_MULT = 6'd24;
  localparam logic [5:0] FN_MULU = 6'd25;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_XOR  = 6'd38;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

  typedef enum logic [2:0] {
    PATH_SEQ, PATH_JUMP, PATH_CALL, PATH_RJMP,
    PATH_BEQ, PATH_BNE, PATH_BGEZ, PATH_BAD
  } path_e;

  typedef struct packed {
    path_e       path;
    logic [25:0] tgt;
    logic [15:0] imm;
  } npc_ctrl_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [IW-1:0] instr_i,
  output npc_ctrl_t     ctrl_o
);
  logic [5:0] opc, fn;

  assign opc = instr_i[31:26];
  assign fn  = instr_i[5:0];

  always_comb begin
    ctrl_o.tgt = instr_i[25:0];
    ctrl_o.imm = instr_i[15:0];
    unique case (opc)
      OPC_SPECIAL: begin
        unique case (fn)
          FN_JR: ctrl_o.path = PATH_RJMP;
          FN_SLL, FN_SRL, FN_SLLV, FN_SRLV, FN_MFHI, FN_MFLO,
          FN_MULT, FN_MULU, FN_ADDU, FN_SUBU, FN_AND, FN_OR,
          FN_XOR, FN_SLT, FN_SLTU: ctrl_o.path = PATH_SEQ;
          default: ctrl_o.path = PATH_BAD;
        endcase
      end
      OPC_BGEZ: ctrl_o.path = PATH_BGEZ;
      OPC_J:    ctrl_o.path = PATH_JUMP;
      OPC_JAL:  ctrl_o.path = PATH_CALL;
      OPC_BEQ:  ctrl_o.path = PATH_BEQ;
      OPC_BNE:  ctrl_o.path = PATH_BNE;
      OPC_ADDIU, OPC_SLTI, OPC_SLTIU, OPC_ANDI, OPC_ORI,
      OPC_XORI, OPC_LUI, OPC_LW, OPC_SW: ctrl_o.path = PATH_SEQ;
      default: ctrl_o.path = PATH_BAD;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XW = 32
) (
  input  logic [XW-1:0] pc_i,
  input  npc_ctrl_t     ctrl_i,
  input  logic [XW-1:0] rs_val_i,
  input  logic [XW-1:0] rt_val_i,
  output logic [XW-1:0] next_pc_o,
  output logic [XW-1:0] link_val_o,
  output logic          is_call_o
);
  localparam int unsigned SEXT_W = XW - 18;
  localparam int unsigned ZEXT_W = XW - 28;

  logic [XW-1:0] seq_pc, br_pc, abs_pc;
  logic          eq;

  assign seq_pc = pc_i + XW'(4);
  // relative to the branch's own address, not the incremented PC
  assign br_pc  = pc_i + {{SEXT_W{ctrl_i.imm[15]}}, ctrl_i.imm, 2'b00};
  assign abs_pc = {{ZEXT_W{1'b0}}, ctrl_i.tgt, 2'b00};
  assign eq     = (rs_val_i == rt_val_i);

  always_comb begin
    unique case (ctrl_i.path)
      PATH_SEQ:  next_pc_o = seq_pc;
      PATH_JUMP,
      PATH_CALL: next_pc_o = abs_pc;
      PATH_RJMP: next_pc_o = rs_val_i;
      PATH_BEQ:  next_pc_o = eq ? br_pc : seq_pc;
      PATH_BNE:  next_pc_o = eq ? seq_pc : br_pc;
      PATH_BGEZ: next_pc_o = rs_val_i[XW-1] ? seq_pc : br_pc;
      default:   next_pc_o = '0;
    endcase
  end

  assign link_val_o = seq_pc;
  assign is_call_o  = (ctrl_i.path == PATH_CALL);
endmodule

// File: rtl/npc_state.sv
module npc_state #(
  parameter int unsigned       XW       = 32,
  parameter int unsigned       CNT_W    = 16,
  parameter logic [XW-1:0]     RESET_PC = 32'h0040_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [XW-1:0]    next_pc_i,
  output logic [XW-1:0]    pc_o,
  output logic             halt_o,
  output logic [CNT_W-1:0] count_o
);
  logic adv;

  assign adv = step_i & ~halt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o    <= RESET_PC;
      halt_o  <= 1'b0;
      count_o <= '0;
    end else if (adv) begin
      pc_o    <= next_pc_i;
      count_o <= count_o + CNT_W'(1);
      if (next_pc_i == '0) halt_o <= 1'b1;
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     XW         = XLEN,
  parameter int unsigned     IMEM_DEPTH = 64,
  parameter int unsigned     CNT_W      = 16,
  parameter logic [XW-1:0]   RESET_PC   = 32'h0040_0000,
  localparam int unsigned    IDX_W      = $clog2(IMEM_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [31:0]      instr_i,
  input  logic [XW-1:0]    rs_val_i,
  input  logic [XW-1:0]    rt_val_i,
  output logic [XW-1:0]    pc_o,
  output logic [IDX_W-1:0] imem_idx_o,
  output logic [XW-1:0]    next_pc_o,
  output logic             link_we_o,
  output logic [XW-1:0]    link_val_o,
  output logic             halt_o,
  output logic [CNT_W-1:0] retired_o
);
  npc_ctrl_t ctrl;
  logic      is_call;

  npc_decode #(.IW(32)) u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  npc_target #(.XW(XW)) u_tgt (
    .pc_i       (pc_o),
    .ctrl_i     (ctrl),
    .rs_val_i   (rs_val_i),
    .rt_val_i   (rt_val_i),
    .next_pc_o  (next_pc_o),
    .link_val_o (link_val_o),
    .is_call_o  (is_call)
  );

  npc_state #(.XW(XW), .CNT_W(CNT_W), .RESET_PC(RESET_PC)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .next_pc_i (next_pc_o),
    .pc_o      (pc_o),
    .halt_o    (halt_o),
    .count_o   (retired_o)
  );

  assign link_we_o  = step_i & ~halt_o & is_call;
  // word-indexed store: byte offset bits dropped
  assign imem_idx_o = pc_o[IDX_W+1:2];
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic [XW-1:0]    pc_o,
  input logic [XW-1:0]    next_pc_o,
  input logic             link_we_o,
  input logic [XW-1:0]    link_val_o,
  input logic             halt_o,
  input logic [CNT_W-1:0] retired_o
);
  AST_PC_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !halt_o) |=> pc_o == $past(next_pc_o)); // R2
  AST_LINK_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_val_o == pc_o + XW'(4)); // R5
  AST_HALT_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !halt_o && next_pc_o == '0) |=> halt_o); // R9
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R10
  AST_HALT_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(pc_o)); // R10
  AST_HALT_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !link_we_o); // R10
  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !halt_o) |=> retired_o == $past(retired_o) + CNT_W'(1)); // R11
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(retired_o)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(retired_o)); // R12
  AST_IDLE_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |-> !link_we_o); // R12
endmodule

bind npc_unit npc_unit_chk #(.XW(XW), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_i),
  .pc_o       (pc_o),
  .next_pc_o  (next_pc_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o),
  .halt_o     (halt_o),
  .retired_o  (retired_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] instr = '0, rs_v = '0, rt_v = '0;
  logic [31:0] pc, npc, lval;
  logic [5:0]  idx;
  logic        lwe, halt;
  logic [15:0] cnt;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  npc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .instr_i(instr),
    .rs_val_i(rs_v), .rt_val_i(rt_v), .pc_o(pc), .imem_idx_o(idx),
    .next_pc_o(npc), .link_we_o(lwe), .link_val_o(lval),
    .halt_o(halt), .retired_o(cnt)
  );

  // {instr, rs, rt, expected next pc, expected link strobe}
  localparam logic [128:0] VEC [12] = '{
    {32'h2401_0005, 32'h0,         32'h0, 32'h0040_0004, 1'b0}, // R2 addiu
    {32'h1022_0003, 32'h5,         32'h5, 32'h0040_0010, 1'b0}, // R7 beq taken
    {32'h1422_FFFE, 32'h7,         32'h7, 32'h0040_0014, 1'b0}, // R7 bne not taken
    {32'h1422_FFFE, 32'h1,         32'h2, 32'h0040_000C, 1'b0}, // R7 bne back
    {32'h0421_FFFF, 32'h7FFF_FFFF, 32'h9, 32'h0040_0008, 1'b0}, // R8 taken, rt ignored
    {32'h0421_FFFF, 32'h8000_0000, 32'h0, 32'h0040_000C, 1'b0}, // R8 negative
    {32'h0C10_0040, 32'h0,         32'h0, 32'h0040_0100, 1'b1}, // R5 call
    {32'h0810_0080, 32'h0,         32'h0, 32'h0040_0200, 1'b0}, // R4 jump
    {32'h03E0_0008, 32'hF000_0100, 32'h0, 32'hF000_0100, 1'b0}, // R6 reg jump
    {32'h0810_0080, 32'h0,         32'h0, 32'h0040_0200, 1'b0}, // R4 no upper merge
    {32'h0022_182B, 32'h0,         32'h0, 32'h0040_0204, 1'b0}, // R2 sltu
    {32'h8C22_0000, 32'h0,         32'h0, 32'h0040_0208, 1'b0}  // R2 lw
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; step = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk); instr = i; rs_v = a; rt_v = b; step = s; #1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    do_reset();
    #1;
    chk("R1 pc", pc, 32'h0040_0000);
    chk("R1 halt", {31'b0, halt}, 32'h0);
    chk("R1 cnt", {16'b0, cnt}, 32'h0);

    for (int k = 0; k < 12; k++) begin
      prev = pc;
      drive(VEC[k][128:97], VEC[k][96:65], VEC[k][64:33], 1'b1);
      chk("R3 idx", {26'b0, idx}, (prev & 32'hFF) >> 2);
      chk("R2/R4-R8 next", npc, VEC[k][32:1]);
      chk("R5 link_we", {31'b0, lwe}, {31'b0, VEC[k][0]});
      if (VEC[k][0]) chk("R5 link_val", lval, prev + 32'd4);
      @(posedge clk); #1;
      chk("R2 pc", pc, VEC[k][32:1]);
      chk("R11 cnt", {16'b0, cnt}, k + 1);
    end

    // R12: idle cycles change nothing
    drive(32'h0C10_0040, 32'h0, 32'h0, 1'b0);
    chk("R12 link_we idle", {31'b0, lwe}, 32'h0);
    repeat (3) @(posedge clk); #1;
    chk("R12 pc hold", pc, 32'h0040_0208);
    chk("R12 cnt hold", {16'b0, cnt}, 32'd12);

    // R9/R10: bad function code halts
    drive(32'h0000_0001, 32'h0, 32'h0, 1'b1);
    chk("R9 bad funct", npc, 32'h0);
    @(posedge clk); #1;
    chk("R10 halt", {31'b0, halt}, 32'h1);
    chk("R10 pc zero", pc, 32'h0);
    chk("R11 cnt halting step", {16'b0, cnt}, 32'd13);
    drive(32'h0C10_0040, 32'h0, 32'h0, 1'b1);
    chk("R10 no link", {31'b0, lwe}, 32'h0);
    repeat (3) @(posedge clk); #1;
    chk("R10 pc frozen", pc, 32'h0);
    chk("R10 sticky", {31'b0, halt}, 32'h1);
    chk("R11 cnt frozen", {16'b0, cnt}, 32'd13);

    // R1 again, then R9: bad opcode
    do_reset(); #1;
    chk("R1 pc re", pc, 32'h0040_0000);
    chk("R1 halt re", {31'b0, halt}, 32'h0);
    drive(32'hFC00_0000, 32'h0, 32'h0, 1'b1);
    chk("R9 bad opcode", npc, 32'h0);
    @(posedge clk); #1;
    chk("R10 halt opcode", {31'b0, halt}, 32'h1);

    // R6/R10: register jump to zero halts
    do_reset();
    drive(32'h03E0_0008, 32'h0, 32'h0, 1'b1);
    chk("R6 jr zero", npc, 32'h0);
    @(posedge clk); #1;
    chk("R10 halt jr", {31'b0, halt}, 32'h1);
    chk("R11 cnt jr", {16'b0, cnt}, 32'd1);

    step = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule